// File: doc/BRIEF.md
# Two-Phase Scan Configuration Chain

This block gives an off-chip controller write and read access to on-chip configuration and status values through a handful of slow pins. The pins are two non-overlapping shift clocks, a serial input, a serial output, a strobe that commits the chain into the chip, and a strobe that loads the chip into the chain. All pins are sampled by the on-chip clock. A rising edge of the first phase takes one bit into a master stage. The falling edge of the second phase moves the master stage into the slave stage that forms the visible chain.

The chain carries several kinds of field:
- a reset bit;
- three writable plain registers;
- a writable 16-bit table, reached through an address subfield and a 4-bit data subfield;
- three read-only status inputs;
- a read-only 16-bit table, reached the same way.

Writes take effect only when the commit strobe is pulsed. Reads take a snapshot into the chain, which the controller then shifts out.

Top module: `scan_cfg_chain`

## Requirements
- R1: A bit moves one stage only when the second-phase pulse ends. The serial input is taken when the first phase rises. `scan_sdo` changes only at the end of a second-phase pulse.
- R2: Rotating exactly 25 bits puts the first bit presented at chain position 0. A following rotation returns the previous image with bit i of the image appearing as the i-th output bit.
- R3: Chain positions, with the low bit first:
  - position 0 is the reset bit;
  - cfg_a is at 1, cfg_b at 2–3, cfg_c at 4–6;
  - the write-table address is at 7–8 and its data at 9–12;
  - sts_a is at 13, sts_b at 14–15, sts_c at 16–18;
  - the read-table address is at 19–20 and its data at 21–24.
- R4: A rising edge of `scan_load_chip` copies the writable fields into the cfg outputs. Shifting and chain loads leave the cfg outputs unchanged.
- R5: A commit with the reset bit clear replaces only the 4-bit slot of `cfg_tbl` at bits [4*addr+3:4*addr], where addr is the write-table address field. The other slots keep their values.
- R6: A commit with the reset bit set loads the reset values instead of the chain data: cfg_a=0, cfg_b=3, cfg_c=0, cfg_tbl=0xAA55.
- R7: Holding `scan_load_chain` high through one phase pair loads the chain in parallel. The writable plain fields take the current cfg values, and the read-only plain fields take the live sts inputs.
- R8: On a chain load, the read-table data field takes the slot of `sts_tbl` selected by the address held in the chain. Both address fields and the reset bit keep their shifted-in values.
- R9: On a chain load, the write-table data field takes the slot of `cfg_tbl` selected by the write-table address held in the chain.
- R10: While `rst_n` is low at a clock edge, the cfg outputs take their reset values and both chain stages clear to zero.
- R11: The two shift phases are never high together. A load_chip rising edge happens only while both phases are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | On-chip clock that samples all pins |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_phi | input | 1 | First shift phase |
| scan_phi_b | input | 1 | Second shift phase, never overlapping the first |
| scan_sdi | input | 1 | Serial data in |
| scan_sdo | output | 1 | Serial data out, chain position 0 |
| scan_load_chip | input | 1 | Commit strobe, chain to cfg outputs |
| scan_load_chain | input | 1 | Snapshot strobe, chip values to chain |
| cfg_a | output | 1 | Writable register A |
| cfg_b | output | 2 | Writable register B |
| cfg_c | output | 3 | Writable register C |
| cfg_tbl | output | 16 | Writable table of four 4-bit slots |
| sts_a | input | 1 | Read-only status A |
| sts_b | input | 2 | Read-only status B |
| sts_c | input | 3 | Read-only status C |
| sts_tbl | input | 16 | Read-only table of four 4-bit slots |

## Verification
The write path is swept over all 64 combinations of the three plain registers. The table address and data vary along with them, so each slot is written several times, and a slot-select error shows up as corruption of a neighbouring slot. The readback path walks all four addresses of both tables, with status values that differ per address. This tells a wrong slot select apart from a wrong field position. Two back-to-back rotations of unlike images check the positional ordering of the output. A single hand-stepped bit shows that the output moves only when the second phase ends. A rotation followed by a snapshot with no commit shows that the cfg outputs hold.

// File: rtl/scan_pkg.sv
// Shared types for the scan configuration chain.
package scan_pkg;

    // Per-cycle events decoded from the synchronised scan pins.
    typedef struct packed {
        logic phi_rise;   // first phase has just risen
        logic phib_fall;  // second phase has just ended
        logic chip_rise;  // commit strobe has just risen
        logic chain_lvl;  // snapshot strobe level
        logic sdi;        // synchronised serial input
    } scan_evt_t;

endpackage

// File: rtl/scan_pin_sync.sv
// Synchronises the five scan input pins to clk and decodes edge events.
// Assumes every pin level is held for at least three clk cycles.
module scan_pin_sync
    import scan_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      phi,
    input  logic      phi_b,
    input  logic      sdi,
    input  logic      load_chip,
    input  logic      load_chain,
    output scan_evt_t evt
);
    localparam int NPIN = 5;

    logic [NPIN-1:0] raw, s1, s2, prev;

    assign raw = {load_chain, load_chip, sdi, phi_b, phi};

    // Two-stage synchroniser plus a history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1   <= '0;
            s2   <= '0;
            prev <= '0;
        end else begin
            s1   <= raw;
            s2   <= s1;
            prev <= s2;
        end
    end

    // Decode single-cycle events from the synchronised levels.
    always_comb begin
        evt.phi_rise  = s2[0] & ~prev[0];
        evt.phib_fall = ~s2[1] & prev[1];
        evt.sdi       = s2[2];
        evt.chip_rise = s2[3] & ~prev[3];
        evt.chain_lvl = s2[4];
    end

    // R11
    phases_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s2[0] && s2[1]));

    // R11
    commit_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s2[3] && !prev[3]) |-> (!s2[0] && !s2[1]));

endmodule

// File: rtl/scan_shift_chain.sv
// Master/slave shift chain. The master stage loads on the first phase,
// either shifting or taking a parallel image. The slave stage copies the
// master when the second phase ends. Position 0 is the output end.
module scan_shift_chain #(
    parameter int LEN = 25
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           phi_rise,
    input  logic           phib_fall,
    input  logic           cap_en,
    input  logic           sdi,
    input  logic [LEN-1:0] cap_img,
    output logic [LEN-1:0] master_q,
    output logic [LEN-1:0] slave_q
);

    // Master stage: take the parallel image or shift toward position 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            master_q <= '0;
        else if (phi_rise)
            master_q <= cap_en ? cap_img : {sdi, slave_q[LEN-1:1]};
    end

    // Slave stage: commit the master when the second phase completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slave_q <= '0;
        else if (phib_fall)
            slave_q <= master_q;
    end

    // R1
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phib_fall |=> $stable(slave_q));

    // R1
    master_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phi_rise |=> $stable(master_q));

endmodule

// File: rtl/scan_shadow_word.sv
// Chip-facing shadow register for one plain writable field.
// Loads on a commit; takes its reset value when the chain reset bit is set.
module scan_shadow_word #(
    parameter int           W   = 1,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         rst_bit,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Commit chain data or the reset value; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST;
        else if (load)
            q <= rst_bit ? RST : d;
    end

    // R4
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

    // R6
    word_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && rst_bit) |=> (q == RST));

endmodule

// File: rtl/scan_shadow_table.sv
// Chip-facing shadow for an addressed table. A commit replaces one DAT_W-wide
// slot chosen by the address; the chain reset bit restores the whole table.
module scan_shadow_table #(
    parameter int               ARR_W = 16,
    parameter int               DAT_W = 4,
    parameter logic [ARR_W-1:0] RST   = '0
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 load,
    input  logic                                 rst_bit,
    input  logic [$clog2(ARR_W/DAT_W)-1:0]       addr,
    input  logic [DAT_W-1:0]                     data,
    output logic [ARR_W-1:0]                     q
);
    localparam int NSLOT  = ARR_W / DAT_W;
    localparam int ADDR_W = $clog2(NSLOT);

    logic [ARR_W-1:0] merged;

    // Read one slot of a table value.
    function automatic logic [DAT_W-1:0] slot_of(input logic [ARR_W-1:0] arr,
                                                 input logic [ADDR_W-1:0] a);
        logic [DAT_W-1:0] r;
        r = '0;
        for (int k = 0; k < NSLOT; k++)
            if (a == k[ADDR_W-1:0]) r = arr[k*DAT_W +: DAT_W];
        return r;
    endfunction

    // Build the table with the addressed slot replaced.
    always_comb begin
        merged = q;
        for (int k = 0; k < NSLOT; k++)
            if (addr == k[ADDR_W-1:0]) merged[k*DAT_W +: DAT_W] = data;
    end

    // Commit the merged table or the reset value; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST;
        else if (load)
            q <= rst_bit ? RST : merged;
    end

    // R5
    slot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !rst_bit) |=> (slot_of(q, $past(addr)) == $past(data)));

    // R4
    table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/scan_cfg_chain.sv
// Top of the scan configuration chain. It places the fields in the chain,
// forms the parallel image used by a chain load, and drives the shadows.
// Assumes the controller keeps each pin level for at least three clk cycles.
module scan_cfg_chain #(
    parameter int               W_A     = 1,
    parameter int               W_B     = 2,
    parameter int               W_C     = 3,
    parameter int               ARR_W   = 16,
    parameter int               DAT_W   = 4,
    parameter logic [W_A-1:0]   RST_A   = 1'd0,
    parameter logic [W_B-1:0]   RST_B   = 2'd3,
    parameter logic [W_C-1:0]   RST_C   = 3'd0,
    parameter logic [ARR_W-1:0] RST_TBL = 16'hAA55
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_phi,
    input  logic             scan_phi_b,
    input  logic             scan_sdi,
    output logic             scan_sdo,
    input  logic             scan_load_chip,
    input  logic             scan_load_chain,
    output logic [W_A-1:0]   cfg_a,
    output logic [W_B-1:0]   cfg_b,
    output logic [W_C-1:0]   cfg_c,
    output logic [ARR_W-1:0] cfg_tbl,
    input  logic [W_A-1:0]   sts_a,
    input  logic [W_B-1:0]   sts_b,
    input  logic [W_C-1:0]   sts_c,
    input  logic [ARR_W-1:0] sts_tbl
);
    import scan_pkg::*;

    localparam int NSLOT  = ARR_W / DAT_W;
    localparam int ADDR_W = $clog2(NSLOT);
    localparam int SEG_W  = ADDR_W + DAT_W;
    localparam int P_RST  = 0;
    localparam int P_A    = P_RST + 1;
    localparam int P_B    = P_A + W_A;
    localparam int P_C    = P_B + W_B;
    localparam int P_WT   = P_C + W_C;
    localparam int P_SA   = P_WT + SEG_W;
    localparam int P_SB   = P_SA + W_A;
    localparam int P_SC   = P_SB + W_B;
    localparam int P_ST   = P_SC + W_C;
    localparam int LEN    = P_ST + SEG_W;

    scan_evt_t        evt;
    logic [LEN-1:0]   master_q, slave_q, cap_img;
    logic [ADDR_W-1:0] wt_addr, st_addr;

    // Select one slot of a table value.
    function automatic logic [DAT_W-1:0] pick(input logic [ARR_W-1:0] arr,
                                              input logic [ADDR_W-1:0] a);
        logic [DAT_W-1:0] r;
        r = '0;
        for (int k = 0; k < NSLOT; k++)
            if (a == k[ADDR_W-1:0]) r = arr[k*DAT_W +: DAT_W];
        return r;
    endfunction

    scan_pin_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .phi        (scan_phi),
        .phi_b      (scan_phi_b),
        .sdi        (scan_sdi),
        .load_chip  (scan_load_chip),
        .load_chain (scan_load_chain),
        .evt        (evt)
    );

    assign wt_addr = slave_q[P_WT +: ADDR_W];
    assign st_addr = slave_q[P_ST +: ADDR_W];

    // Parallel image: cfg values and live status; addresses and reset bit kept.
    always_comb begin
        cap_img                          = '0;
        cap_img[P_RST]                   = slave_q[P_RST];
        cap_img[P_A +: W_A]              = cfg_a;
        cap_img[P_B +: W_B]              = cfg_b;
        cap_img[P_C +: W_C]              = cfg_c;
        cap_img[P_WT +: ADDR_W]          = wt_addr;
        cap_img[P_WT + ADDR_W +: DAT_W]  = pick(cfg_tbl, wt_addr);
        cap_img[P_SA +: W_A]             = sts_a;
        cap_img[P_SB +: W_B]             = sts_b;
        cap_img[P_SC +: W_C]             = sts_c;
        cap_img[P_ST +: ADDR_W]          = st_addr;
        cap_img[P_ST + ADDR_W +: DAT_W]  = pick(sts_tbl, st_addr);
    end

    scan_shift_chain #(.LEN(LEN)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .phi_rise  (evt.phi_rise),
        .phib_fall (evt.phib_fall),
        .cap_en    (evt.chain_lvl),
        .sdi       (evt.sdi),
        .cap_img   (cap_img),
        .master_q  (master_q),
        .slave_q   (slave_q)
    );

    assign scan_sdo = slave_q[0];

    scan_shadow_word #(.W(W_A), .RST(RST_A)) u_sh_a (
        .clk(clk), .rst_n(rst_n), .load(evt.chip_rise), .rst_bit(slave_q[P_RST]),
        .d(slave_q[P_A +: W_A]), .q(cfg_a));

    scan_shadow_word #(.W(W_B), .RST(RST_B)) u_sh_b (
        .clk(clk), .rst_n(rst_n), .load(evt.chip_rise), .rst_bit(slave_q[P_RST]),
        .d(slave_q[P_B +: W_B]), .q(cfg_b));

    scan_shadow_word #(.W(W_C), .RST(RST_C)) u_sh_c (
        .clk(clk), .rst_n(rst_n), .load(evt.chip_rise), .rst_bit(slave_q[P_RST]),
        .d(slave_q[P_C +: W_C]), .q(cfg_c));

    scan_shadow_table #(.ARR_W(ARR_W), .DAT_W(DAT_W), .RST(RST_TBL)) u_sh_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (evt.chip_rise),
        .rst_bit (slave_q[P_RST]),
        .addr    (wt_addr),
        .data    (slave_q[P_WT + ADDR_W +: DAT_W]),
        .q       (cfg_tbl)
    );

    // R8
    addr_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.phi_rise && evt.chain_lvl) |=>
        (master_q[P_ST +: ADDR_W] == $past(slave_q[P_ST +: ADDR_W]) &&
         master_q[P_WT +: ADDR_W] == $past(slave_q[P_WT +: ADDR_W])));

    // R1
    slave_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt.phib_fall |=> (slave_q == $past(master_q)));

endmodule

// File: tb/scan_cfg_chain_tb.sv
`timescale 1ns/1ps
module scan_cfg_chain_tb;
    localparam int LEN = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic phi = 0, phib = 0, sdi = 0, lchip = 0, lchain = 0;
    logic sdo;
    logic [0:0]  cfg_a;
    logic [1:0]  cfg_b;
    logic [2:0]  cfg_c;
    logic [15:0] cfg_tbl;
    logic [0:0]  sts_a = '0;
    logic [1:0]  sts_b = '0;
    logic [2:0]  sts_c = '0;
    logic [15:0] sts_tbl = '0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    scan_cfg_chain u_dut (
        .clk(clk), .rst_n(rst_n), .scan_phi(phi), .scan_phi_b(phib),
        .scan_sdi(sdi), .scan_sdo(sdo), .scan_load_chip(lchip),
        .scan_load_chain(lchain), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_c(cfg_c),
        .cfg_tbl(cfg_tbl), .sts_a(sts_a), .sts_b(sts_b), .sts_c(sts_c),
        .sts_tbl(sts_tbl)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        repeat (6) @(negedge clk);
    endtask

    // Chain image from fields (layout of R3).
    function automatic logic [LEN-1:0] img(input logic rb, input logic [0:0] a,
        input logic [1:0] b, input logic [2:0] c, input logic [1:0] wa,
        input logic [3:0] wd, input logic [0:0] sa, input logic [1:0] sb,
        input logic [2:0] sc, input logic [1:0] ra, input logic [3:0] rd);
        return {rd, ra, sc, sb, sa, wd, wa, c, b, a, rb};
    endfunction

    function automatic logic [3:0] slot(input logic [15:0] t, input int k);
        return t[k*4 +: 4];
    endfunction

    task automatic rotate(input logic [LEN-1:0] din, output logic [LEN-1:0] dout);
        for (int i = 0; i < LEN; i++) begin
            sdi = din[i];
            dout[i] = sdo;
            phi = 1; step(); phi = 0; step();
            phib = 1; step(); phib = 0; step();
        end
    endtask

    task automatic commit();
        lchip = 1; step(); lchip = 0; step();
    endtask

    task automatic snapshot();
        lchain = 1; step();
        phi = 1; step(); phi = 0; step();
        phib = 1; step(); phib = 0; step();
        lchain = 0; step();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [LEN-1:0] o, x, y;
        logic [15:0] mtbl;
        logic [3:0] wd;
        repeat (5) @(negedge clk);
        rst_n = 1;
        step();
        // R10 reset state
        chk(cfg_a == 1'd0, "R10 cfg_a", cfg_a, 0);
        chk(cfg_b == 2'd3, "R10 cfg_b", cfg_b, 3);
        chk(cfg_c == 3'd0, "R10 cfg_c", cfg_c, 0);
        chk(cfg_tbl == 16'hAA55, "R10 cfg_tbl", cfg_tbl, 16'hAA55);
        chk(sdo == 1'b0, "R10 sdo", sdo, 0);

        // R4 R5 write sweep over all plain values
        mtbl = 16'hAA55;
        for (int v = 0; v < 64; v++) begin
            wd = 4'((v * 7 + 3) % 16);
            rotate(img(1'b0, v[0:0], v[2:1], v[5:3], v[1:0], wd, 1'b1, 2'd1,
                       3'd7, 2'd2, 4'h9), o);
            mtbl[(v % 4)*4 +: 4] = wd;
            commit();
            chk(cfg_a == v[0:0], "R4 cfg_a", cfg_a, v[0:0]);
            chk(cfg_b == v[2:1], "R4 cfg_b", cfg_b, v[2:1]);
            chk(cfg_c == v[5:3], "R4 cfg_c", cfg_c, v[5:3]);
            chk(cfg_tbl == mtbl, "R5 cfg_tbl slot", cfg_tbl, mtbl);
        end

        // R2 positional ordering across two rotations
        x = 25'h1A5_3C96;
        y = 25'h0F0_F0F1;
        rotate(x, o);
        rotate(y, o);
        chk(o == x, "R2 readback order", o, x);

        // R1 hand-stepped bit: output moves only when the second phase ends
        chk(sdo == y[0], "R1 sdo before", sdo, y[0]);
        sdi = 0; phi = 1; step();
        chk(sdo == y[0], "R1 sdo after phi", sdo, y[0]);
        phi = 0; step(); phib = 1; step();
        chk(sdo == y[0], "R1 sdo during phi_b", sdo, y[0]);
        phib = 0; step();
        chk(sdo == y[1], "R1 sdo after phi_b", sdo, y[1]);

        // R4 hold: shifting and snapshot without commit leave cfg unchanged
        chk(cfg_a == 1'd1 && cfg_b == 2'd3 && cfg_c == 3'd7, "R4 hold plain",
            {cfg_a, cfg_b, cfg_c}, {1'd1, 2'd3, 3'd7});
        snapshot();
        chk(cfg_tbl == mtbl, "R4 hold table", cfg_tbl, mtbl);

        // R7 R8 R9 snapshot readback over all addresses
        for (int k = 0; k < 4; k++) begin
            sts_a = k[0:0];
            sts_b = 2'(3 - k);
            sts_c = 3'(k * 2 + 1);
            sts_tbl = 16'hABCD ^ 16'(k * 16'h1111);
            rotate(img(1'b0, 1'b0, 2'd0, 3'd0, k[1:0], 4'h0, 1'b0, 2'd0, 3'd0,
                       2'(3 - k), 4'h0), o);
            snapshot();
            rotate('0, o);
            chk(o[0] == 1'b0, "R8 reset bit kept", o[0], 0);
            chk(o[1] == cfg_a && o[3:2] == cfg_b && o[6:4] == cfg_c,
                "R7 writable readback", o[6:1], {cfg_c, cfg_b, cfg_a});
            chk(o[8:7] == k[1:0], "R8 write addr kept", o[8:7], k);
            chk(o[12:9] == slot(mtbl, k), "R9 write slot", o[12:9], slot(mtbl, k));
            chk(o[13] == sts_a && o[15:14] == sts_b && o[18:16] == sts_c,
                "R7 status readback", o[18:13], {sts_c, sts_b, sts_a});
            chk(o[20:19] == 2'(3 - k), "R8 read addr kept", o[20:19], 3 - k);
            chk(o[24:21] == slot(sts_tbl, 3 - k), "R8 read slot", o[24:21],
                slot(sts_tbl, 3 - k));
        end

        // R6 reset bit at commit overrides chain data
        rotate(img(1'b1, 1'b1, 2'd0, 3'd6, 2'd1, 4'h7, 1'b0, 2'd0, 3'd0,
                   2'd0, 4'h0), o);
        commit();
        chk(cfg_a == 1'd0, "R6 cfg_a", cfg_a, 0);
        chk(cfg_b == 2'd3, "R6 cfg_b", cfg_b, 3);
        chk(cfg_c == 3'd0, "R6 cfg_c", cfg_c, 0);
        chk(cfg_tbl == 16'hAA55, "R6 cfg_tbl", cfg_tbl, 16'hAA55);

        // R5 slot 2 write on the reset table
        rotate(img(1'b0, 1'b0, 2'd3, 3'd0, 2'd2, 4'hB, 1'b0, 2'd0, 3'd0,
                   2'd0, 4'h0), o);
        commit();
        chk(cfg_tbl == 16'hAB55, "R5 slot 2 write", cfg_tbl, 16'hAB55);

        // R11 protocol obeyed throughout; checked by design assertions
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule